// File: doc/BRIEF.md
# Multi-Lane Training Deskew Aligner

This block removes cycle-level skew between the lanes of a parallel link whose lanes are routed separately and can arrive many clock cycles apart. Once the link handshake is reported done, the block watches every lane for a training word of all ones that the far end launched on all lanes at the same moment. It records, per lane, the cycle in which that word first shows up.

When every lane has reported in, the block takes the latest arrival as the reference. It gives each lane a delay equal to how far that lane ran ahead of the reference, so the latest lane passes with no added delay. After that, the lanes leave the block in step and carry ordinary serial data, one word of `LANE_W` bits per lane per cycle (one bit or one nibble in typical use). The largest skew it can correct is set by the depth of the per-lane delay buffers. A spread larger than that depth, or a lane that stays silent for too long, is reported as an error and the lanes are not declared aligned.

Top module: `deskew_aligner`

## Requirements
- R1: A training word that arrives in or before the cycle in which `hs_done_i` is high is not recorded. Measurement covers only the cycles after that handshake cycle.
- R2: On each lane, the training word is a lane word whose `LANE_W` bits are all 1. Only the first such word after the handshake sets that lane's arrival time; later all-ones words on that lane change nothing.
- R3: Once aligned, each lane is delayed by the latest arrival time minus its own arrival time. Every lane output then equals the common launched stream delayed by the largest lane skew.
- R4: If every lane arrives and the spread from the earliest to the latest arrival is at most `MAX_DEPTH` cycles (16 by default), `aligned_o` rises and `skew_err_o` stays low. A spread of exactly `MAX_DEPTH` is accepted.
- R5: If the arrival spread exceeds `MAX_DEPTH`, `skew_err_o` rises and `aligned_o` stays low.
- R6: Arrival times count from 0 in the first cycle after the handshake. A lane with no training word by count `TIMEOUT-1` (63 by default) makes `skew_err_o` rise and keeps `aligned_o` low.
- R7: `aligned_o` and `skew_err_o` are never high together, and both are low while measurement runs.
- R8: A high `hs_done_i` restarts training from any state. Both flags read low in the following cycle, and the measurement starts over.
- R9: After reset, both flags are low and every lane passes through with zero delay (`lane_data_o` equals `lane_data_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_done_i | input | 1 | One-cycle strobe: handshake complete, start training |
| lane_data_i | input | NUM_LANES*LANE_W | Incoming lane words; lane n occupies bits [n*LANE_W +: LANE_W] |
| lane_data_o | output | NUM_LANES*LANE_W | Deskewed lane words, same packing |
| aligned_o | output | 1 | Training succeeded; lanes are deskewed |
| skew_err_o | output | 1 | Training failed: spread too large or lane timed out |

## Verification
The main sweep increases the spread from 0 to `MAX_DEPTH+2`. In each step it rotates which lane arrives last and places the other lanes at intermediate offsets. This separates delays computed against the latest lane from delays tied to a fixed lane position, and it tests the accept/reject boundary at exactly `MAX_DEPTH`.

After each pulse, random data follows on every lane and is compared cycle by cycle with the launched stream shifted by the largest skew. Any wrong per-lane tap shows up as a data mismatch. Random all-ones words after the pulse, together with one long all-ones burst, separate "first arrival" from "any all-ones word".

Two pulses placed at the last accepted count and one count later pin down the timeout. A pulse sent before the handshake, followed by silence, must end in a timeout rather than an alignment. All scenarios run back to back without reset, so each new handshake is also tested as a restart from both the aligned and the failed state.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MEAS    = 2'd1,
    ST_ALIGNED = 2'd2,
    ST_FAIL    = 2'd3
  } train_state_e;
endpackage

// File: rtl/lane_arrival_stamp.sv
module lane_arrival_stamp #(
  parameter int unsigned LANE_W = 4,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              meas_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [LANE_W-1:0] data_i,
  output logic              seen_o,
  output logic [CNT_W-1:0]  stamp_o
);
  logic             seen_q;
  logic [CNT_W-1:0] stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      stamp_q <= '0;
    end else if (clr_i) begin
      seen_q  <= 1'b0;
      stamp_q <= '0;
    end else if (meas_en_i && !seen_q && (&data_i)) begin
      seen_q  <= 1'b1;
      stamp_q <= cnt_i;
    end
  end

  assign seen_o  = seen_q;
  assign stamp_o = stamp_q;

  // R2
  stamp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !clr_i) |=> $stable(stamp_q));

  // R1
  no_early_stamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_en_i && !clr_i) |=> $stable(seen_q));
endmodule

// File: rtl/skew_calc.sv
module skew_calc #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned CNT_W     = 7
) (
  input  logic [NUM_LANES*CNT_W-1:0] stamps_i,
  output logic [CNT_W-1:0]           max_o,
  output logic [CNT_W-1:0]           spread_o
);
  logic [CNT_W-1:0] hi, lo;

  always_comb begin
    hi = stamps_i[CNT_W-1:0];
    lo = stamps_i[CNT_W-1:0];
    for (int l = 1; l < NUM_LANES; l++) begin
      if (stamps_i[l*CNT_W +: CNT_W] > hi) hi = stamps_i[l*CNT_W +: CNT_W];
      if (stamps_i[l*CNT_W +: CNT_W] < lo) lo = stamps_i[l*CNT_W +: CNT_W];
    end
  end

  assign max_o    = hi;
  assign spread_o = hi - lo;
endmodule

// File: rtl/lane_delay_line.sv
module lane_delay_line #(
  parameter int unsigned LANE_W    = 4,
  parameter int unsigned MAX_DEPTH = 16,
  parameter int unsigned SEL_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANE_W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [LANE_W-1:0] data_o
);
  localparam int unsigned SR_W = MAX_DEPTH * LANE_W;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SR_W-LANE_W-1:0], data_i};
  end

  // tap k (k>=1) holds the word seen k cycles earlier
  always_comb begin
    data_o = data_i;
    for (int k = 1; k <= MAX_DEPTH; k++) begin
      if (sel_i == SEL_W'(k)) data_o = sr_q[(k-1)*LANE_W +: LANE_W];
    end
  end

  // R3
  one_cycle_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_W'(1)) |-> (data_o == $past(data_i)));
endmodule

// File: rtl/deskew_aligner.sv
module deskew_aligner
  import deskew_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = 4,
  parameter int unsigned MAX_DEPTH = 16,
  parameter int unsigned TIMEOUT   = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        hs_done_i,
  input  logic [NUM_LANES*LANE_W-1:0] lane_data_i,
  output logic [NUM_LANES*LANE_W-1:0] lane_data_o,
  output logic                        aligned_o,
  output logic                        skew_err_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam int unsigned SEL_W = $clog2(MAX_DEPTH + 1);
  localparam logic [CNT_W-1:0] TIMEOUT_C = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(MAX_DEPTH);

  train_state_e state_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [SEL_W-1:0]           sel_q [NUM_LANES];
  logic [NUM_LANES-1:0]       seen;
  logic [NUM_LANES*CNT_W-1:0] stamps;
  logic [CNT_W-1:0]           max_stamp, spread;
  logic                       meas_en, all_seen;

  assign meas_en  = (state_q == ST_MEAS) && (cnt_q < TIMEOUT_C);
  assign all_seen = &seen;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_arrival_stamp #(.LANE_W(LANE_W), .CNT_W(CNT_W)) i_stamp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (hs_done_i),
      .meas_en_i(meas_en),
      .cnt_i    (cnt_q),
      .data_i   (lane_data_i[g*LANE_W +: LANE_W]),
      .seen_o   (seen[g]),
      .stamp_o  (stamps[g*CNT_W +: CNT_W])
    );

    lane_delay_line #(.LANE_W(LANE_W), .MAX_DEPTH(MAX_DEPTH), .SEL_W(SEL_W)) i_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .data_i(lane_data_i[g*LANE_W +: LANE_W]),
      .sel_i (sel_q[g]),
      .data_o(lane_data_o[g*LANE_W +: LANE_W])
    );
  end

  skew_calc #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) i_calc (
    .stamps_i(stamps),
    .max_o   (max_stamp),
    .spread_o(spread)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      for (int l = 0; l < NUM_LANES; l++) sel_q[l] <= '0;
    end else if (hs_done_i) begin
      state_q <= ST_MEAS;
      cnt_q   <= '0;
      for (int l = 0; l < NUM_LANES; l++) sel_q[l] <= '0;
    end else if (state_q == ST_MEAS) begin
      if (all_seen) begin
        if (spread > DEPTH_C) begin
          state_q <= ST_FAIL;
        end else begin
          state_q <= ST_ALIGNED;
          for (int l = 0; l < NUM_LANES; l++)
            sel_q[l] <= SEL_W'(max_stamp - stamps[l*CNT_W +: CNT_W]);
        end
      end else if (cnt_q == TIMEOUT_C) begin
        state_q <= ST_FAIL;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign aligned_o  = (state_q == ST_ALIGNED);
  assign skew_err_o = (state_q == ST_FAIL);

  // R8
  hs_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_done_i |=> (!aligned_o && !skew_err_o));

  // R4
  aligned_spread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> (all_seen && spread <= DEPTH_C));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_seen && spread > DEPTH_C) |-> !aligned_o);

  // R6
  timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MEAS && cnt_q == TIMEOUT_C && !all_seen && !hs_done_i) |=> skew_err_o);
endmodule

// File: tb/test_deskew_aligner.sv
module test_deskew_aligner;
  localparam int NL = 4;
  localparam int LW = 4;
  localparam int DEPTH = 16;
  localparam int TMO = 64;
  localparam int H = 3;
  localparam int T_END = H + TMO + 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0;
  logic [NL*LW-1:0] lane_in = '0;
  logic [NL*LW-1:0] lane_out;
  logic aligned, serr;

  int n_chk = 0;
  int n_fail = 0;
  logic [LW-1:0] src [128];
  int skew [NL];

  always #5 clk = ~clk;

  deskew_aligner #(.NUM_LANES(NL), .LANE_W(LW), .MAX_DEPTH(DEPTH), .TIMEOUT(TMO)) i_deskew_aligner (
    .clk_i(clk), .rst_ni(rst_n), .hs_done_i(hs),
    .lane_data_i(lane_in), .lane_data_o(lane_out),
    .aligned_o(aligned), .skew_err_o(serr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] src_at(input int i);
    return (i < 0 || i > 127) ? '0 : src[i];
  endfunction

  // p: launch index of the pulse; burst: length of the all-ones run; tail: random data after it
  task automatic run_case(input int s0, input int s1, input int s2, input int s3,
                          input int p, input int burst, input bit tail, input string tag);
    int maxsk, mn, mx, st;
    bit ok;
    skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    for (int i = 0; i < 128; i++) begin
      if (i >= p && i < p + burst) src[i] = '1;
      else if (i >= p + burst && tail) src[i] = LW'($urandom % (1 << LW));
      else src[i] = '0;
    end
    maxsk = 0; mn = 1 << 20; mx = -(1 << 20); ok = 1'b1;
    for (int l = 0; l < NL; l++) begin
      if (skew[l] > maxsk) maxsk = skew[l];
      st = p + skew[l] - H - 1;  // arrival count after handshake
      if (st < 0 || st > TMO - 1) ok = 1'b0;
      if (st < mn) mn = st;
      if (st > mx) mx = st;
    end
    if (mx - mn > DEPTH) ok = 1'b0;
    for (int t = 0; t <= T_END; t++) begin
      @(negedge clk);
      hs = (t == H);
      for (int l = 0; l < NL; l++) lane_in[l*LW +: LW] = src_at(t - skew[l]);
      #1;
      if (t == H + 1) begin
        // R7 R8
        chk(!aligned && !serr, "R8", {aligned, serr}, 2'b00);
      end
      if (t == H + TMO + 5) begin
        chk(aligned == ok && serr == !ok, tag, {aligned, serr}, {ok, !ok});
      end
      if (t > H + TMO + 5 && ok) begin
        for (int l = 0; l < NL; l++)
          chk(lane_out[l*LW +: LW] == src_at(t - maxsk), "R3",
              lane_out[l*LW +: LW], src_at(t - maxsk));
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) skew[l] = 0;
    #23;
    @(negedge clk);
    lane_in = 16'hA5C3;
    #1;
    // R9
    chk(lane_out == lane_in, "R9", lane_out, lane_in);
    chk(!aligned && !serr, "R9", {aligned, serr}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    lane_in = 16'h3C5A;
    #1;
    chk(lane_out == lane_in, "R9", lane_out, lane_in);
    chk(!aligned && !serr, "R7", {aligned, serr}, 2'b00);

    // spread sweep with rotating latest lane: R4 up to DEPTH, R5 beyond
    for (int s = 0; s <= DEPTH + 2; s++) begin
      int v [4];
      v[0] = 0; v[1] = s / 3; v[2] = s; v[3] = (2 * s) / 3;
      run_case(v[s % 4], v[(1 + s) % 4], v[(2 + s) % 4], v[(3 + s) % 4],
               H + 2, 1, 1'b1, (s <= DEPTH) ? "R4" : "R5");
    end

    // R2: long all-ones burst, only the first word counts
    run_case(0, 5, 9, 2, H + 1, 6, 1'b1, "R2");
    // R6: last accepted count, then one count too late
    run_case(0, 0, 0, 0, H + TMO, 1, 1'b1, "R6");
    run_case(0, 0, 0, 0, H + TMO + 1, 1, 1'b1, "R6");
    run_case(0, 3, 1, TMO, H + 1, 1, 1'b0, "R6");
    // R1: pulse only before and during the handshake cycle
    run_case(0, 0, 0, 0, H - 1, 2, 1'b0, "R1");
    // restart from the failed state and deskew again
    run_case(7, 0, 16, 4, H + 4, 1, 1'b1, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule